// File: doc/BRIEF.md
# E3 Frame-Slave Serial Transmit Framer

This block sits between upstream terminal equipment and the E3 line side. Both share one local transmit clock at the nominal E3 rate of 34.368 MHz. The upstream side is the frame master. It drives a serial payload bit on every clock and pulses a one-bit frame reference on the first bit of each frame. The block follows that reference. It keeps a position counter across the 1536-bit frame. It replaces the overhead positions with framing content and sends the result as a single framed serial bit.

The upstream equipment needs warning of each overhead slot so that it can hold back payload for that slot. The block therefore raises an overhead indicator one bit period before each overhead bit. The stream runs at a fixed bit rate and has no back-pressure. The indicator is the only flow signal, and any bit that arrives in an overhead slot is dropped.

Frame layout:
- The frame is four 384-bit sets.
- Positions 0 to 9 carry the alignment word 1111010000, sent left to right.
- Position 10 carries a configurable alarm bit and position 11 a configurable national bit.
- The first four positions of sets 2 to 4 are forced to zero.

A reference that arrives part-way through a frame restarts the count and raises a one-cycle flag.

Top module: `e3fs_tx_slave`

## Requirements
- R1: While rst_n is low, ser_out, oh_ind and ref_mismatch are 0. After reset the block stays idle with all three outputs at 0, whatever ser_in carries, until the first rising edge of frame_ref.
- R2: A clock edge that samples frame_ref high, where frame_ref was low at the edge before, takes the bit sampled at that edge as frame bit 0. ser_out shows each frame bit in the cycle after the edge that samples it.
- R3: Frame bits 0 to 9 are sent as the word 1111010000, bit 0 first (bit 0 = 1, bit 4 = 0, bit 5 = 1, bit 9 = 0).
- R4: Frame bit 10 carries the alarm_bit input and frame bit 11 carries the natl_bit input, each as sampled at the edge that takes that bit.
- R5: Frame bits 384–387, 768–771 and 1152–1155 are sent as 0, and the ser_in value sampled at those positions is discarded.
- R6: Every frame position not named in R3, R4 or R5 sends the ser_in value sampled for that position.
- R7: Take the cycle after the edge that samples frame bit p. In that cycle oh_ind is 1 exactly when position (p+2) mod 1536 is an overhead bit. The upstream side then sees the warning while it presents bit p+1. For example, oh_ind is high while bit 1535 is presented, which warns of bit 0.
- R8: Without a reference pulse, the position wraps from 1535 to 0 and a new frame starts with the alignment word.
- R9: A rising edge of frame_ref while running restarts the frame at bit 0 at that edge. If the bit before was not 1535, ref_mismatch is 1 for exactly one cycle. A reference that lines up with the wrap, or the first one after idle, leaves ref_mismatch at 0.
- R10: Holding frame_ref high for more than one clock does not restart the frame again. Only the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local transmit bit clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_bit | input | 1 | Value placed in frame bit 10 |
| natl_bit | input | 1 | Value placed in frame bit 11 |
| frame_ref | input | 1 | Frame reference from upstream, high on bit 0, already synchronous to clk |
| ser_in | input | 1 | Serial payload bit from upstream |
| ser_out | output | 1 | Framed serial bit toward the line |
| oh_ind | output | 1 | Early warning that the bit after the one now presented is overhead |
| ref_mismatch | output | 1 | One-cycle flag for a reference that arrived mid-frame |

## Verification
Across one full frame the payload input follows a pattern that mixes bit 0 and bit 2 of the position. This makes a passed-through bit differ from a forced constant at the positions sampled. Each zeroed slot is therefore tested where the dropped payload would have been 1.

A second frame runs with no reference, with the alarm and national inputs swapped. It separates a real wrap from a restart and shows that the configurable bits are live.

A reference part-way through a frame is held high for two cycles. Fixed-word checks a few bits later separate a single restart from a second restart. The flag is compared against a reference that arrives exactly at the wrap.

A mid-run reset followed by payload with no reference confirms that the block falls back to idle.

// File: rtl/e3fs_pkg.sv
package e3fs_pkg;

  localparam int unsigned E3_FRAME_BITS = 1536;
  localparam int unsigned E3_SET_BITS   = 384;
  localparam int unsigned E3_NUM_SETS   = 4;
  localparam int unsigned E3_ALIGN_LEN  = 10;
  localparam int unsigned E3_JC_LEN     = 4;
  localparam logic [E3_ALIGN_LEN-1:0] E3_ALIGN_WORD = 10'b1111010000;

  // Kind of content carried at one frame position.
  typedef enum logic [2:0] {
    SLOT_PAYLOAD,
    SLOT_ALIGN,
    SLOT_ALARM,
    SLOT_NATL,
    SLOT_JC
  } slot_kind_e;

endpackage

// File: rtl/e3fs_edge_det.sv
module e3fs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl && !lvl_q;

endmodule

// File: rtl/e3fs_frame_cnt.sv
module e3fs_frame_cnt #(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [POS_W-1:0] cur_pos,
  output logic             cur_valid,
  output logic [POS_W-1:0] pos_q,
  output logic             running,
  output logic             mismatch
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic at_last;
  assign at_last = (pos_q == LAST_POS);

  // Position of the bit sampled at the coming edge.
  always_comb begin
    if (start)        cur_pos = '0;
    else if (at_last) cur_pos = '0;
    else              cur_pos = pos_q + POS_W'(1);
  end

  assign cur_valid = start || running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      running  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      if (cur_valid) pos_q <= cur_pos;
      running  <= cur_valid;
      mismatch <= start && running && !at_last;
    end
  end

endmodule

// File: rtl/e3fs_slot_class.sv
module e3fs_slot_class
  import e3fs_pkg::*;
#(
  parameter int unsigned FRAME_BITS = E3_FRAME_BITS,
  parameter int unsigned SET_BITS   = E3_SET_BITS,
  parameter int unsigned NUM_SETS   = E3_NUM_SETS,
  parameter int unsigned ALIGN_LEN  = E3_ALIGN_LEN,
  parameter int unsigned JC_LEN     = E3_JC_LEN,
  localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
  input  logic [POS_W-1:0] pos,
  output slot_kind_e       kind
);

  localparam logic [POS_W-1:0] ALARM_POS = POS_W'(ALIGN_LEN);
  localparam logic [POS_W-1:0] NATL_POS  = POS_W'(ALIGN_LEN + 1);

  logic [NUM_SETS-2:0] jc_hit;

  // Justification-control run at the head of every set except the first.
  for (genvar s = 1; s < NUM_SETS; s++) begin : g_jc
    localparam logic [POS_W-1:0] JC_LO = POS_W'(s * SET_BITS);
    localparam logic [POS_W-1:0] JC_HI = POS_W'(s * SET_BITS + JC_LEN);
    assign jc_hit[s-1] = (pos >= JC_LO) && (pos < JC_HI);
  end

  always_comb begin
    if (pos < POS_W'(ALIGN_LEN)) kind = SLOT_ALIGN;
    else if (pos == ALARM_POS)   kind = SLOT_ALARM;
    else if (pos == NATL_POS)    kind = SLOT_NATL;
    else if (|jc_hit)            kind = SLOT_JC;
    else                         kind = SLOT_PAYLOAD;
  end

endmodule

// File: rtl/e3fs_tx_slave.sv
module e3fs_tx_slave
  import e3fs_pkg::*;
#(
  parameter int unsigned FRAME_BITS = E3_FRAME_BITS,
  parameter int unsigned SET_BITS   = E3_SET_BITS,
  parameter int unsigned NUM_SETS   = E3_NUM_SETS,
  parameter int unsigned ALIGN_LEN  = E3_ALIGN_LEN,
  parameter int unsigned JC_LEN     = E3_JC_LEN,
  parameter logic [ALIGN_LEN-1:0] ALIGN_WORD = E3_ALIGN_WORD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_bit,
  input  logic natl_bit,
  input  logic frame_ref,
  input  logic ser_in,
  output logic ser_out,
  output logic oh_ind,
  output logic ref_mismatch
);

  localparam int unsigned POS_W = $clog2(FRAME_BITS);
  localparam int unsigned LOOKAHEAD = 2;

  logic             ref_rise;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] pos_q;
  logic             cur_valid;
  logic             running;
  logic             mismatch;
  logic [POS_W-1:0] la_pos;
  logic [POS_W:0]   la_sum;
  slot_kind_e       cur_kind;
  slot_kind_e       la_kind;
  logic             align_val;
  logic             next_bit;

  e3fs_edge_det u_ref_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (frame_ref),
    .rise  (ref_rise)
  );

  e3fs_frame_cnt #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ref_rise),
    .cur_pos   (cur_pos),
    .cur_valid (cur_valid),
    .pos_q     (pos_q),
    .running   (running),
    .mismatch  (mismatch)
  );

  e3fs_slot_class #(
    .FRAME_BITS(FRAME_BITS), .SET_BITS(SET_BITS), .NUM_SETS(NUM_SETS),
    .ALIGN_LEN(ALIGN_LEN), .JC_LEN(JC_LEN)
  ) u_cur_class (
    .pos  (cur_pos),
    .kind (cur_kind)
  );

  // Position two bits ahead: the one after the bit upstream presents next.
  assign la_sum = {1'b0, cur_pos} + (POS_W+1)'(LOOKAHEAD);
  assign la_pos = (la_sum >= (POS_W+1)'(FRAME_BITS))
                ? POS_W'(la_sum - (POS_W+1)'(FRAME_BITS))
                : la_sum[POS_W-1:0];

  e3fs_slot_class #(
    .FRAME_BITS(FRAME_BITS), .SET_BITS(SET_BITS), .NUM_SETS(NUM_SETS),
    .ALIGN_LEN(ALIGN_LEN), .JC_LEN(JC_LEN)
  ) u_la_class (
    .pos  (la_pos),
    .kind (la_kind)
  );

  // Alignment word is sent most significant bit first.
  always_comb begin
    align_val = 1'b0;
    for (int i = 0; i < int'(ALIGN_LEN); i++) begin
      if (cur_pos == POS_W'(i)) align_val = ALIGN_WORD[ALIGN_LEN-1-i];
    end
  end

  always_comb begin
    unique case (cur_kind)
      SLOT_ALIGN: next_bit = align_val;
      SLOT_ALARM: next_bit = alarm_bit;
      SLOT_NATL:  next_bit = natl_bit;
      SLOT_JC:    next_bit = 1'b0;
      default:    next_bit = ser_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_out <= 1'b0;
      oh_ind  <= 1'b0;
    end else begin
      ser_out <= cur_valid && next_bit;
      oh_ind  <= cur_valid && (la_kind != SLOT_PAYLOAD);
    end
  end

  assign ref_mismatch = mismatch;

endmodule

// File: rtl/e3fs_tx_checks.sv
module e3fs_tx_checks #(
  parameter int unsigned FRAME_BITS = 1536,
  parameter int unsigned SET_BITS   = 384,
  parameter int unsigned NUM_SETS   = 4,
  parameter int unsigned JC_LEN     = 4,
  localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_ref,
  input logic             ser_out,
  input logic             oh_ind,
  input logic             ref_mismatch,
  input logic [POS_W-1:0] pos_q,
  input logic             running
);

  logic in_jc;
  always_comb begin
    in_jc = 1'b0;
    for (int s = 1; s < int'(NUM_SETS); s++) begin
      if (int'(pos_q) >= s * int'(SET_BITS) && int'(pos_q) < s * int'(SET_BITS) + int'(JC_LEN))
        in_jc = 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!ser_out && !oh_ind && !ref_mismatch));

  assert_ref_starts_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_ref) |=> (ser_out && oh_ind && running && pos_q == '0));

  assert_jc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && in_jc) |-> !ser_out);

  assert_warn_frame_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pos_q == POS_W'(FRAME_BITS - 2)) |-> oh_ind);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pos_q == POS_W'(FRAME_BITS - 1)) |=> (running && pos_q == '0));

  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mismatch |=> !ref_mismatch);

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mismatch |-> ($past(frame_ref) && pos_q == '0));

endmodule

bind e3fs_tx_slave e3fs_tx_checks #(
  .FRAME_BITS(FRAME_BITS), .SET_BITS(SET_BITS), .NUM_SETS(NUM_SETS), .JC_LEN(JC_LEN)
) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_ref    (frame_ref),
  .ser_out      (ser_out),
  .oh_ind       (oh_ind),
  .ref_mismatch (ref_mismatch),
  .pos_q        (pos_q),
  .running      (running)
);

// File: tb/sim_e3fs_tx_slave.sv
module sim_e3fs_tx_slave;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, alarm_bit, natl_bit, frame_ref, ser_in;
  logic ser_out, oh_ind, ref_mismatch;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  e3fs_tx_slave u0 (
    .clk(clk), .rst_n(rst_n), .alarm_bit(alarm_bit), .natl_bit(natl_bit),
    .frame_ref(frame_ref), .ser_in(ser_in),
    .ser_out(ser_out), .oh_ind(oh_ind), .ref_mismatch(ref_mismatch)
  );

  // {position, expected ser_out, expected oh_ind}; payload pattern from pay().
  localparam int NV = 19;
  localparam logic [12:0] VECS [0:NV-1] = '{
    {11'd0,    1'b1, 1'b1}, {11'd4,    1'b0, 1'b1}, {11'd5,    1'b1, 1'b1},
    {11'd9,    1'b0, 1'b1}, {11'd10,   1'b1, 1'b0}, {11'd11,   1'b0, 1'b0},
    {11'd12,   1'b1, 1'b0}, {11'd13,   1'b0, 1'b0}, {11'd382,  1'b1, 1'b1},
    {11'd383,  1'b0, 1'b1}, {11'd385,  1'b0, 1'b1}, {11'd387,  1'b0, 1'b0},
    {11'd388,  1'b1, 1'b0}, {11'd769,  1'b0, 1'b1}, {11'd1153, 1'b0, 1'b1},
    {11'd1156, 1'b1, 1'b0}, {11'd1533, 1'b0, 1'b0}, {11'd1534, 1'b1, 1'b1},
    {11'd1535, 1'b0, 1'b1}
  };

  function automatic logic pay(input int p);
    return 1'((p & 1) ^ ((p >> 2) & 1));
  endfunction

  function automatic string tag_of(input int p);
    if (p < 10) return "R3";
    if (p < 12) return "R4";
    if ((p >= 384 && p < 388) || (p >= 768 && p < 772) || (p >= 1152 && p < 1156))
      return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive away from the edge, then sample after it.
  task automatic tick(input logic r, input logic d);
    frame_ref = r;
    ser_in    = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; alarm_bit = 1'b1; natl_bit = 1'b0; frame_ref = 1'b0; ser_in = 1'b0;
    @(negedge clk);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    check("R1", "ser_out in reset", ser_out, 1'b0);
    check("R1", "oh_ind in reset", oh_ind, 1'b0);
    check("R1", "ref_mismatch in reset", ref_mismatch, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) tick(1'b0, 1'b1);
    check("R1", "ser_out idle with payload 1", ser_out, 1'b0);
    check("R1", "oh_ind idle", oh_ind, 1'b0);

    // Table walk over one full frame (R2..R7).
    begin
      int idx = 0;
      for (int p = 0; p < 1536; p++) begin
        tick(p == 0, pay(p));
        if (p == 0) check("R9", "no flag on first reference", ref_mismatch, 1'b0);
        if (idx < NV && int'(VECS[idx][12:2]) == p) begin
          check(tag_of(p), $sformatf("ser_out pos %0d", p), ser_out, VECS[idx][1]);
          check("R7", $sformatf("oh_ind pos %0d", p), oh_ind, VECS[idx][0]);
          idx++;
        end
      end
    end

    // Free-running wrap with swapped configurable bits (R8, R4).
    alarm_bit = 1'b0; natl_bit = 1'b1;
    for (int p = 0; p < 100; p++) begin
      tick(1'b0, pay(p));
      if (p == 0) begin
        check("R8", "align bit 0 after wrap", ser_out, 1'b1);
        check("R8", "no flag at wrap", ref_mismatch, 1'b0);
      end
      if (p == 10) check("R4", "alarm bit now 0", ser_out, 1'b0);
      if (p == 11) check("R4", "national bit now 1", ser_out, 1'b1);
    end

    // Mid-frame reference held high for two cycles (R9, R10).
    tick(1'b1, 1'b0);
    check("R9", "restart sends align bit 0", ser_out, 1'b1);
    check("R9", "flag on mid-frame reference", ref_mismatch, 1'b1);
    tick(1'b1, 1'b0);
    check("R9", "flag lasts one cycle", ref_mismatch, 1'b0);
    check("R10", "held reference keeps bit 1", ser_out, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    check("R10", "align bit 4 after held reference", ser_out, 1'b0);
    tick(1'b0, 1'b0);
    check("R10", "align bit 5 after held reference", ser_out, 1'b1);
    for (int p = 6; p < 1536; p++) tick(1'b0, pay(p));

    // Reference aligned with the wrap.
    tick(1'b1, 1'b0);
    check("R9", "aligned reference no flag", ref_mismatch, 1'b0);
    check("R2", "aligned reference bit 0", ser_out, 1'b1);

    // Mid-run reset returns to idle (R1).
    rst_n = 1'b0;
    tick(1'b0, 1'b1);
    check("R1", "ser_out after mid-run reset", ser_out, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) tick(1'b0, 1'b1);
    check("R1", "stays idle without reference", ser_out, 1'b0);
    check("R1", "oh_ind idle after reset", oh_ind, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule